// File: doc/BRIEF.md
# Codec Reset and Power-State Controller

This block decides when an audio codec's logic is cleared, when its serial link may run and which analog units are powered. It handles three kinds of reset. An asynchronous hardware reset clears everything. A one-cycle register-reset strobe, raised when the controller writes the reset register, clears register contents only. A warm wake-up is the frame-sync line held high while the bit clock is stopped, and it brings the link back without touching any register.

The eight power-down request bits from the register bank are decoded into per-unit power-down enables. The analog units are the ADC with its input mux, the DAC, the mixer and the reference voltage. Each has a ready flag that drops at once when its unit is powered down. A ready flag rises again only after a programmable settle count, and the reference must be ready before the other three start counting.

Setting request bit 4 shuts the link at the end of slot 2 of the current frame, which a framer reports with a strobe. The levels of serial data-out and sync at the release of hardware reset select one of two test modes.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: While `rstHwN` is low, `fullRst` and `regRst` are 1, and `linkEn`, `readyStat`, `ateMode` and `vendorMode` are all 0. `fullRst` falls at the first clock edge after `rstHwN` rises.
- R2: A one-cycle `regZeroWr` pulse makes `regRst` 1 for exactly one cycle, starting after the next clock edge. `fullRst` and `linkEn` do not change.
- R3: After reset release, `linkEn` rises at clock edge RESTART_CYCLES+1 (edge 22 by default, at least 162.8 ns with an 8 ns clock). After a warm wake, it rises at edge RESTART_CYCLES+2 counted from the fall of sync.
- R4: A rise of `pdReq[4]` arms a link shutdown. `linkEn` falls after the first later `slot2End` strobe. A `slot2End` strobe with nothing armed has no effect. `pdLink` equals the inverse of `linkEn`.
- R5: With the link off, `syncIn` held high for at least WARM_MIN_CYCLES edges while `bitClkRunning` is 0 restarts the link when sync falls. A shorter pulse, or a pulse while the bit clock runs, leaves `linkEn` at 0. A wake never raises `regRst`, and the link then stays on although `pdReq[4]` is still 1.
- R6: The power-down outputs are decoded from `pdReq` as follows. Bit 0 powers down the ADC. Bit 1 powers down the DAC. Bit 2 powers down the mixer. Bit 3 powers down the ADC, DAC, mixer and Vref. Bit 5 drives `pdIntClk`, bit 6 drives `pdLineOut` and bit 7 drives `eapd`.
- R7: The fields of `readyStat` are bit 3 Vref, bit 2 mixer, bit 1 DAC and bit 0 ADC. A bit reads 0 in the same cycle that its unit's power-down enable is 1.
- R8: A ready bit sets only after its unit has been powered for its settle count. Vref counts VREF_SETTLE (100) edges. The mixer, DAC and ADC then count 40, 30 and 30 edges after Vref is ready.
- R9: At reset release, `sdoIn` high sets `ateMode` and `syncIn` high sets `vendorMode`. When both are high, only `ateMode` is set. The flags hold until the next hardware reset.
- R10: While either test flag is set, all `readyStat` bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstHwN | input | 1 | Asynchronous active-low hardware (cold) reset |
| syncIn | input | 1 | Frame sync line level |
| sdoIn | input | 1 | Serial data-out line level |
| bitClkRunning | input | 1 | 1 while the bit clock toggles |
| slot2End | input | 1 | Strobe at the end of slot 2 of each frame |
| regZeroWr | input | 1 | Strobe for a write to the reset register |
| pdReq | input | 8 | Power-down request bits from the register bank |
| fullRst | output | 1 | Reset for all codec logic |
| regRst | output | 1 | Reset for register contents only |
| linkEn | output | 1 | Bit clock and serial input may run |
| pdAdc | output | 1 | ADC and input mux power-down |
| pdDac | output | 1 | DAC power-down |
| pdMix | output | 1 | Mixer power-down |
| pdVref | output | 1 | Reference voltage power-down |
| pdLink | output | 1 | Link power-down |
| pdIntClk | output | 1 | Internal clock stop |
| pdLineOut | output | 1 | Line-level output power-down |
| eapd | output | 1 | External amplifier power-down pin |
| readyStat | output | 4 | Ready flags: Vref, mixer, DAC, ADC |
| ateMode | output | 1 | In-circuit test mode: link pins tri-stated |
| vendorMode | output | 1 | Vendor test mode flag |

## Verification
The assertions check four rules on every cycle:
- a mixer, DAC or ADC ready flag is never set without Vref ready;
- the link only goes down right after a slot-2 strobe;
- the test flags are exclusive and frozen after release;
- a register reset outside cold reset always follows a write strobe.

Only the directed scenarios can show the following:
- the exact restart distances after reset and after a wake;
- that short or clock-running sync pulses are ignored;
- the settle windows themselves;
- the full decode of the power-down bits.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;

  localparam int PD_BITS = 8;
  localparam int LINK_SHUT_BIT = 4;

  // strobes from the control half to the power datapath
  typedef struct packed {
    logic coldClr;   // full reset in progress
    logic testHold;  // a test mode is active
    logic linkOff;   // link is not running
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    LS_GAP = 2'd0,   // waiting out the restart gap
    LS_ON  = 2'd1,   // link running
    LS_OFF = 2'd2    // link shut, watching for a wake
  } linkState_t;

endpackage

// File: rtl/cpc_settle_timer.sv
module cpc_settle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rstHwN,
  input  logic enable,
  output logic ready
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] count;
  logic             done;

  always_ff @(posedge clk or negedge rstHwN) begin
    if (!rstHwN) begin
      count <= '0;
      done  <= 1'b0;
    end else if (!enable) begin
      count <= '0;
      done  <= 1'b0;
    end else if (!done) begin
      if (count == CNT_W'(LIMIT - 1)) done <= 1'b1;
      count <= count + 1'b1;
    end
  end

  // drops in the same cycle the unit loses power
  assign ready = done & enable;

endmodule

// File: rtl/cpc_reset_ctrl.sv
module cpc_reset_ctrl
  import codec_pwr_pkg::*;
#(
  parameter int RESTART_CYCLES  = 21,
  parameter int WARM_MIN_CYCLES = 125
) (
  input  logic       clk,
  input  logic       rstHwN,
  input  logic       syncIn,
  input  logic       sdoIn,
  input  logic       bitClkRunning,
  input  logic       slot2End,
  input  logic       regZeroWr,
  input  logic       linkShutReq,
  output logic       fullRst,
  output logic       regRst,
  output logic       linkEn,
  output logic       ateMode,
  output logic       vendorMode,
  output ctlStrobe_t strobe
);
  localparam int GAP_W  = $clog2(RESTART_CYCLES + 1);
  localparam int WARM_W = $clog2(WARM_MIN_CYCLES + 1);

  linkState_t        state;
  logic [GAP_W-1:0]  gapCnt;
  logic [WARM_W-1:0] syncCnt;
  logic              shutPrev;
  logic              shutArmed;
  logic              capturePending;

  always_ff @(posedge clk or negedge rstHwN) begin
    if (!rstHwN) begin
      fullRst        <= 1'b1;
      regRst         <= 1'b1;
      linkEn         <= 1'b0;
      state          <= LS_GAP;
      gapCnt         <= '0;
      syncCnt        <= '0;
      shutPrev       <= 1'b0;
      shutArmed      <= 1'b0;
      capturePending <= 1'b1;
      ateMode        <= 1'b0;
      vendorMode     <= 1'b0;
    end else begin
      fullRst  <= 1'b0;
      regRst   <= regZeroWr;
      shutPrev <= linkShutReq;

      // test strap levels taken at the first edge after release
      if (capturePending) begin
        ateMode        <= sdoIn;
        vendorMode     <= syncIn & ~sdoIn;
        capturePending <= 1'b0;
      end

      // a fresh shutdown request arms; a withdrawn one disarms
      if (linkShutReq && !shutPrev) shutArmed <= 1'b1;
      else if (!linkShutReq)        shutArmed <= 1'b0;

      unique case (state)
        LS_GAP: begin
          if (gapCnt == GAP_W'(RESTART_CYCLES)) begin
            state  <= LS_ON;
            linkEn <= 1'b1;
            gapCnt <= '0;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        LS_ON: begin
          if (shutArmed && slot2End) begin
            state     <= LS_OFF;
            linkEn    <= 1'b0;
            shutArmed <= 1'b0;
            syncCnt   <= '0;
          end
        end
        LS_OFF: begin
          shutArmed <= 1'b0;
          if (syncIn && !bitClkRunning) begin
            if (syncCnt != WARM_W'(WARM_MIN_CYCLES)) syncCnt <= syncCnt + 1'b1;
          end else if (!syncIn && syncCnt == WARM_W'(WARM_MIN_CYCLES)) begin
            state   <= LS_GAP;
            gapCnt  <= '0;
            syncCnt <= '0;
          end else begin
            syncCnt <= '0;
          end
        end
        default: state <= LS_GAP;
      endcase
    end
  end

  assign strobe.coldClr  = fullRst;
  assign strobe.testHold = ateMode | vendorMode;
  assign strobe.linkOff  = ~linkEn;

  // R4: link only drops right after a slot-2 strobe
  a_r4_fall_after_slot2: assert property (@(posedge clk) disable iff (!rstHwN)
    $fell(linkEn) |-> $past(slot2End));

  // R9: test flags never both set
  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rstHwN)
    !(ateMode && vendorMode));

  // R9: test flags frozen once sampled
  a_r9_flags_frozen: assert property (@(posedge clk) disable iff (!rstHwN)
    !$past(capturePending) |-> ($stable(ateMode) && $stable(vendorMode)));

  // R2: register reset outside cold reset comes from a write strobe
  a_r2_regrst_source: assert property (@(posedge clk) disable iff (!rstHwN)
    (regRst && !fullRst) |-> $past(regZeroWr));

endmodule

// File: rtl/cpc_power_path.sv
module cpc_power_path
  import codec_pwr_pkg::*;
#(
  parameter int VREF_SETTLE = 100,
  parameter int MIX_SETTLE  = 40,
  parameter int DAC_SETTLE  = 30,
  parameter int ADC_SETTLE  = 30
) (
  input  logic       clk,
  input  logic       rstHwN,
  input  ctlStrobe_t strobe,
  input  logic [6:0] pdBits,   // request bits 7,6,5,3,2,1,0
  output logic       pdAdc,
  output logic       pdDac,
  output logic       pdMix,
  output logic       pdVref,
  output logic       pdLink,
  output logic       pdIntClk,
  output logic       pdLineOut,
  output logic       eapd,
  output logic [3:0] readyStat
);
  localparam int NUM_LOAD = 3;   // units that wait on Vref

  function automatic int settleOf(input int idx);
    case (idx)
      0:       settleOf = ADC_SETTLE;
      1:       settleOf = DAC_SETTLE;
      default: settleOf = MIX_SETTLE;
    endcase
  endfunction

  logic                base;
  logic                vrefRdy;
  logic [NUM_LOAD-1:0] loadPd;
  logic [NUM_LOAD-1:0] loadRdy;

  // mixer-with-Vref-off request takes everything analog down
  assign pdVref    = pdBits[3];
  assign pdAdc     = pdBits[0] | pdBits[3];
  assign pdDac     = pdBits[1] | pdBits[3];
  assign pdMix     = pdBits[2] | pdBits[3];
  assign pdIntClk  = pdBits[4];
  assign pdLineOut = pdBits[5];
  assign eapd      = pdBits[6];
  assign pdLink    = strobe.linkOff;

  assign base   = ~strobe.coldClr & ~strobe.testHold;
  assign loadPd = {pdMix, pdDac, pdAdc};

  cpc_settle_timer #(.LIMIT(VREF_SETTLE)) uVref (
    .clk    (clk),
    .rstHwN (rstHwN),
    .enable (base & ~pdVref),
    .ready  (vrefRdy)
  );

  for (genvar i = 0; i < NUM_LOAD; i++) begin : gLoad
    cpc_settle_timer #(.LIMIT(settleOf(i))) uTimer (
      .clk    (clk),
      .rstHwN (rstHwN),
      .enable (base & vrefRdy & ~loadPd[i]),
      .ready  (loadRdy[i])
    );
  end

  assign readyStat = {vrefRdy, loadRdy};

  // R8: no load unit ready without the reference
  a_r8_vref_first: assert property (@(posedge clk) disable iff (!rstHwN)
    (|readyStat[2:0]) |-> readyStat[3]);

  // R8: ADC ready rises only after a powered cycle with Vref up
  a_r8_adc_rise: assert property (@(posedge clk) disable iff (!rstHwN)
    $rose(readyStat[0]) |-> ($past(!pdAdc) && $past(readyStat[3])));

  // R10: test modes keep every ready flag low
  a_r10_test_hold: assert property (@(posedge clk) disable iff (!rstHwN)
    strobe.testHold |-> (readyStat == 4'b0000));

endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import codec_pwr_pkg::*;
#(
  parameter int RESTART_CYCLES  = 21,
  parameter int WARM_MIN_CYCLES = 125,
  parameter int VREF_SETTLE     = 100,
  parameter int MIX_SETTLE      = 40,
  parameter int DAC_SETTLE      = 30,
  parameter int ADC_SETTLE      = 30
) (
  input  logic       clk,
  input  logic       rstHwN,
  input  logic       syncIn,
  input  logic       sdoIn,
  input  logic       bitClkRunning,
  input  logic       slot2End,
  input  logic       regZeroWr,
  input  logic [7:0] pdReq,
  output logic       fullRst,
  output logic       regRst,
  output logic       linkEn,
  output logic       pdAdc,
  output logic       pdDac,
  output logic       pdMix,
  output logic       pdVref,
  output logic       pdLink,
  output logic       pdIntClk,
  output logic       pdLineOut,
  output logic       eapd,
  output logic [3:0] readyStat,
  output logic       ateMode,
  output logic       vendorMode
);
  ctlStrobe_t strobe;

  cpc_reset_ctrl #(
    .RESTART_CYCLES  (RESTART_CYCLES),
    .WARM_MIN_CYCLES (WARM_MIN_CYCLES)
  ) uCtrl (
    .clk           (clk),
    .rstHwN        (rstHwN),
    .syncIn        (syncIn),
    .sdoIn         (sdoIn),
    .bitClkRunning (bitClkRunning),
    .slot2End      (slot2End),
    .regZeroWr     (regZeroWr),
    .linkShutReq   (pdReq[LINK_SHUT_BIT]),
    .fullRst       (fullRst),
    .regRst        (regRst),
    .linkEn        (linkEn),
    .ateMode       (ateMode),
    .vendorMode    (vendorMode),
    .strobe        (strobe)
  );

  cpc_power_path #(
    .VREF_SETTLE (VREF_SETTLE),
    .MIX_SETTLE  (MIX_SETTLE),
    .DAC_SETTLE  (DAC_SETTLE),
    .ADC_SETTLE  (ADC_SETTLE)
  ) uPath (
    .clk       (clk),
    .rstHwN    (rstHwN),
    .strobe    (strobe),
    .pdBits    ({pdReq[7:5], pdReq[3:0]}),
    .pdAdc     (pdAdc),
    .pdDac     (pdDac),
    .pdMix     (pdMix),
    .pdVref    (pdVref),
    .pdLink    (pdLink),
    .pdIntClk  (pdIntClk),
    .pdLineOut (pdLineOut),
    .eapd      (eapd),
    .readyStat (readyStat)
  );

endmodule

// File: tb/tb_codec_pwr_ctrl.sv
module tb_codec_pwr_ctrl;
  localparam int RESTART = 21;
  localparam int WARM    = 125;

  logic clk = 1'b0;
  logic rstHwN = 1'b0, syncIn = 1'b0, sdoIn = 1'b0, bitClkRunning = 1'b0;
  logic slot2End = 1'b0, regZeroWr = 1'b0;
  logic [7:0] pdReq = 8'h00;
  logic fullRst, regRst, linkEn, pdAdc, pdDac, pdMix, pdVref, pdLink;
  logic pdIntClk, pdLineOut, eapd, ateMode, vendorMode;
  logic [3:0] readyStat;

  int total = 0;
  int bad = 0;
  bit regRstSeen;

  always #4 clk = ~clk;

  codec_pwr_ctrl #(.RESTART_CYCLES(RESTART), .WARM_MIN_CYCLES(WARM),
    .VREF_SETTLE(100), .MIX_SETTLE(40), .DAC_SETTLE(30), .ADC_SETTLE(30)) dut (
    .clk(clk), .rstHwN(rstHwN), .syncIn(syncIn), .sdoIn(sdoIn),
    .bitClkRunning(bitClkRunning), .slot2End(slot2End), .regZeroWr(regZeroWr),
    .pdReq(pdReq), .fullRst(fullRst), .regRst(regRst), .linkEn(linkEn),
    .pdAdc(pdAdc), .pdDac(pdDac), .pdMix(pdMix), .pdVref(pdVref), .pdLink(pdLink),
    .pdIntClk(pdIntClk), .pdLineOut(pdLineOut), .eapd(eapd),
    .readyStat(readyStat), .ateMode(ateMode), .vendorMode(vendorMode));

  always @(posedge clk) if (regRst && rstHwN) regRstSeen <= 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // cold reset with given straps; returns edges from release until linkEn
  task automatic coldReset(input bit sdo, input bit syn, output int edges);
    @(negedge clk);
    rstHwN = 1'b0; sdoIn = sdo; syncIn = syn; pdReq = 8'h00;
    waitNeg(150);
    check(fullRst == 1 && regRst == 1, "R1 resets held", {fullRst, regRst}, 3);
    check(linkEn == 0 && readyStat == 0 && ateMode == 0 && vendorMode == 0,
          "R1 outputs idle", {linkEn, readyStat, ateMode, vendorMode}, 0);
    rstHwN = 1'b1;
    edges = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1;
      edges++;
      if (edges == 2) begin sdoIn = 1'b0; syncIn = 1'b0; end
      if (linkEn) break;
    end
    check(fullRst == 0, "R1 fullRst released", fullRst, 0);
  endtask

  task automatic t_cold_and_settle();
    int e;
    coldReset(1'b0, 1'b0, e);
    check(e == RESTART + 1, "R3 restart after cold", e, RESTART + 1);
    waitNeg(90 - e);
    check(readyStat == 4'h0, "R8 nothing ready early", readyStat, 0);
    waitNeg(15);
    check(readyStat == 4'h8, "R8 vref first", readyStat, 8);
    waitNeg(95);
    check(readyStat == 4'hF, "R8 all ready", readyStat, 15);
  endtask

  task automatic t_decode();
    logic [6:0] exp [8];
    exp[0] = 7'b0000001; exp[1] = 7'b0000010; exp[2] = 7'b0000100;
    exp[3] = 7'b0001111; exp[4] = 7'b0000000; exp[5] = 7'b0010000;
    exp[6] = 7'b0100000; exp[7] = 7'b1000000;
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); pdReq = 8'(1 << b); #1;
      check({eapd, pdLineOut, pdIntClk, pdVref, pdMix, pdDac, pdAdc} == exp[b],
            "R6 decode", {eapd, pdLineOut, pdIntClk, pdVref, pdMix, pdDac, pdAdc}, exp[b]);
    end
    @(negedge clk); pdReq = 8'h00;
    waitNeg(200);
    @(negedge clk); pdReq = 8'h01; #1;
    check(readyStat == 4'hE, "R7 adc clears at once", readyStat, 14);
    @(negedge clk); pdReq = 8'h08; #1;
    check(readyStat == 4'h0, "R7 vref down clears all", readyStat, 0);
    @(negedge clk); pdReq = 8'h00;
    waitNeg(50);
    check(readyStat == 4'h0, "R8 vref still settling", readyStat, 0);
    waitNeg(55);
    check(readyStat == 4'h8, "R8 vref settled alone", readyStat, 8);
    waitNeg(80);
    check(readyStat == 4'hF, "R8 loads settled", readyStat, 15);
  endtask

  task automatic t_regreset();
    @(negedge clk); regZeroWr = 1'b1;
    @(negedge clk); regZeroWr = 1'b0;
    check(regRst == 1 && fullRst == 0 && linkEn == 1, "R2 pulse",
          {regRst, fullRst, linkEn}, 5);
    @(negedge clk);
    check(regRst == 0, "R2 single cycle", regRst, 0);
  endtask

  task automatic t_shutdown();
    @(negedge clk); slot2End = 1'b1;
    @(negedge clk); slot2End = 1'b0;
    waitNeg(2);
    check(linkEn == 1, "R4 unarmed slot2 ignored", linkEn, 1);
    pdReq = 8'h10;
    waitNeg(3);
    check(linkEn == 1, "R4 waits for slot2", linkEn, 1);
    slot2End = 1'b1;
    @(negedge clk); slot2End = 1'b0;
    check(linkEn == 0 && pdLink == 1, "R4 link shut", {linkEn, pdLink}, 1);
  endtask

  task automatic t_warm();
    int e;
    regRstSeen = 1'b0;
    bitClkRunning = 1'b1; syncIn = 1'b1;
    waitNeg(200);
    syncIn = 1'b0; bitClkRunning = 1'b0;
    waitNeg(40);
    check(linkEn == 0, "R5 running clock ignored", linkEn, 0);
    syncIn = 1'b1; waitNeg(50); syncIn = 1'b0;
    waitNeg(40);
    check(linkEn == 0, "R5 short pulse ignored", linkEn, 0);
    syncIn = 1'b1; waitNeg(130); syncIn = 1'b0;
    e = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); #1; e++;
      if (linkEn) break;
    end
    check(e == RESTART + 2, "R3 restart after wake", e, RESTART + 2);
    waitNeg(50);
    check(linkEn == 1, "R5 link stays with bit 4 set", linkEn, 1);
    check(regRstSeen == 0, "R5 registers untouched", regRstSeen, 0);
    @(negedge clk); pdReq = 8'h00;
  endtask

  task automatic t_testmodes();
    int e;
    coldReset(1'b1, 1'b0, e);
    check(ateMode == 1 && vendorMode == 0, "R9 ate strap", {ateMode, vendorMode}, 2);
    waitNeg(300);
    check(readyStat == 0, "R10 ready held in test", readyStat, 0);
    coldReset(1'b0, 1'b1, e);
    check(ateMode == 0 && vendorMode == 1, "R9 vendor strap", {ateMode, vendorMode}, 1);
    coldReset(1'b1, 1'b1, e);
    check(ateMode == 1 && vendorMode == 0, "R9 ate priority", {ateMode, vendorMode}, 2);
    coldReset(1'b0, 1'b0, e);
    check(ateMode == 0 && vendorMode == 0, "R1 flags cleared", {ateMode, vendorMode}, 0);
  endtask

  initial begin
    t_cold_and_settle();
    t_decode();
    t_regreset();
    t_shutdown();
    t_warm();
    t_testmodes();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule